// File: doc/BRIEF.md
# Ethernet Receive Frame Classifier

This block sits on the receive side of a 10/100 Ethernet MAC, directly behind the line decoder. It takes a byte stream that starts with the synchronisation pattern ahead of a frame. It finds the start-of-frame delimiter and pulls out the two station addresses and the two-byte length/type word. It then decides two things about the frame: whether it is meant for this station, and whether the two-byte word is a payload length (a frame that carries a logical link control header) or a protocol identifier (a frame whose data goes straight to the network layer).

Data bytes after the header go out as a valid-qualified stream with a last marker. The final four bytes of every frame are the check sequence, and they are never delivered as payload. A four-stage delay line holds them back, so the block needs no knowledge of the frame length in advance. A frame that ends before its header is complete is reported as a runt. Integrity checking of the check sequence and all buffering belong to later stages.

Top module: `eth_rx_classifier`

## Requirements
- R1: While idle, a 0x55 byte starts the delimiter hunt. Further 0x55 bytes keep the hunt going, and a 0xD5 byte during the hunt begins the header. A 0xD5 byte seen while idle (with no 0x55 before it) starts nothing.
- R2: During the hunt, any byte other than 0x55 or 0xD5 returns the block to idle. A 0x55 byte that arrives with the end marker also returns it to idle. No header is taken and no frame completion is reported.
- R3: The 14 bytes after the delimiter are captured as follows. The first 6 form `dstAddr`, with the first byte in bits 47:40. The next 6 form `srcAddr` in the same order. The last 2 form `lenType`, most significant byte first. `hdrValid` pulses for exactly one cycle, in the cycle after the 14th header byte is accepted.
- R4: `isLength` is 1 when `lenType` is 1500 or less, and 0 when it is 1501 or more.
- R5: `addrMatch` is 1 when `dstAddr` equals the station address sampled at the delimiter byte, or when `dstAddr` is all ones. Changes to `stationAddr` after the delimiter have no effect on the current frame.
- R6: Every byte after the header, except the last four, appears once on `payByte` with `payValid`, in arrival order. Each payload byte is output in the cycle after the byte four positions later is accepted.
- R7: `payLast` is high together with the final payload byte. A frame with four or fewer bytes after the header produces no payload at all.
- R8: A byte accepted with `inEnd` in header or payload state gives one `frameDone` pulse in the next cycle. `runt` is high with it exactly when fewer than 14 header bytes had been received.
- R9: After reset, `hdrValid`, `frameDone`, `runt`, `payValid` and `payLast` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Byte on inByte is valid this cycle |
| inByte | input | 8 | Received line byte |
| inEnd | input | 1 | Qualified by inValid: this byte is the last of the frame |
| stationAddr | input | 48 | This station's address, sampled at the delimiter |
| dstAddr | output | 48 | Captured destination address |
| srcAddr | output | 48 | Captured source address |
| lenType | output | 16 | Captured length/type word |
| hdrValid | output | 1 | One-cycle pulse: header fields complete |
| addrMatch | output | 1 | Destination is this station or broadcast |
| isLength | output | 1 | 1 = length (LLC framing), 0 = protocol type |
| payValid | output | 1 | payByte carries a payload byte |
| payByte | output | 8 | Payload byte |
| payLast | output | 1 | Final payload byte of the frame |
| frameDone | output | 1 | One-cycle pulse: frame ended |
| runt | output | 1 | With frameDone: frame ended inside the header |

## Verification
The checker treats `inEnd` as meaningful only together with `inValid`. It also assumes that no new frame begins until the previous frame's end marker has been accepted. The bench always raises `inEnd` on a valid byte and closes every frame before it starts the next. It inserts idle bubbles between bytes, which leaves the field-stability and pulse-shape properties unaffected.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_HDR, ST_PAY} rxState_e;

  typedef struct packed {
    logic capSta;
    logic clrPipe;
    logic shiftHdr;
    logic pushPay;
    logic endPay;
  } rxStrobe_t;
endpackage

// File: rtl/eth_rx_ctrl.sv
module eth_rx_ctrl
  import eth_rx_pkg::*;
#(
  parameter int HDR_BYTES = 14,
  parameter logic [7:0] PRE_BYTE = 8'h55,
  parameter logic [7:0] SFD_BYTE = 8'hD5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      inValid,
  input  logic [7:0] inByte,
  input  logic      inEnd,
  output rxStrobe_t strb,
  output logic      hdrValid,
  output logic      frameDone,
  output logic      runt
);
  localparam int CW = $clog2(HDR_BYTES);
  localparam logic [CW-1:0] LAST_IDX = CW'(HDR_BYTES - 1);

  rxState_e state;
  logic [CW-1:0] hdrCnt;

  always_comb begin
    strb = '0;
    case (state)
      ST_HUNT: if (inValid && !inEnd && inByte == SFD_BYTE) begin
        strb.capSta  = 1'b1;
        strb.clrPipe = 1'b1;
      end
      ST_HDR: strb.shiftHdr = inValid;
      ST_PAY: begin
        strb.pushPay = inValid;
        strb.endPay  = inValid && inEnd;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hdrCnt    <= '0;
      hdrValid  <= 1'b0;
      frameDone <= 1'b0;
      runt      <= 1'b0;
    end else begin
      hdrValid  <= 1'b0;
      frameDone <= 1'b0;
      runt      <= 1'b0;
      case (state)
        ST_IDLE: if (inValid && !inEnd && inByte == PRE_BYTE) state <= ST_HUNT;
        ST_HUNT: if (inValid) begin
          if (inEnd) state <= ST_IDLE;
          else if (inByte == SFD_BYTE) begin
            state  <= ST_HDR;
            hdrCnt <= '0;
          end else if (inByte != PRE_BYTE) state <= ST_IDLE;
        end
        ST_HDR: if (inValid) begin
          hdrCnt <= hdrCnt + 1'b1;
          if (hdrCnt == LAST_IDX) begin
            hdrValid <= 1'b1;
            if (inEnd) begin
              frameDone <= 1'b1;
              state     <= ST_IDLE;
            end else state <= ST_PAY;
          end else if (inEnd) begin
            frameDone <= 1'b1;
            runt      <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_PAY: if (inValid && inEnd) begin
          frameDone <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eth_rx_dp.sv
module eth_rx_dp
  import eth_rx_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int LT_W      = 16,
  parameter int FCS_BYTES = 4,
  parameter int MAX_LEN   = 1500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rxStrobe_t         strb,
  input  logic [7:0]        inByte,
  input  logic [ADDR_W-1:0] staIn,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [LT_W-1:0]   lenType,
  output logic              addrMatch,
  output logic              isLength,
  output logic              payValid,
  output logic [7:0]        payByte,
  output logic              payLast
);
  localparam int HDR_W = 2 * ADDR_W + LT_W;
  localparam int FW    = $clog2(FCS_BYTES + 1);
  localparam logic [FW-1:0] FULL = FW'(FCS_BYTES);

  logic [HDR_W-1:0]  hdrReg;
  logic [ADDR_W-1:0] staReg;
  logic [7:0]        dly [FCS_BYTES];
  logic [FW-1:0]     fill;

  assign dstAddr   = hdrReg[HDR_W-1 -: ADDR_W];
  assign srcAddr   = hdrReg[LT_W +: ADDR_W];
  assign lenType   = hdrReg[LT_W-1:0];
  assign addrMatch = (dstAddr == staReg) || (&dstAddr);
  assign isLength  = (lenType <= LT_W'(MAX_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdrReg <= '0;
      staReg <= '0;
    end else begin
      if (strb.capSta)   staReg <= staIn;
      if (strb.shiftHdr) hdrReg <= {hdrReg[HDR_W-9:0], inByte};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill     <= '0;
      payValid <= 1'b0;
      payLast  <= 1'b0;
      payByte  <= '0;
      for (int i = 0; i < FCS_BYTES; i++) dly[i] <= '0;
    end else begin
      payValid <= 1'b0;
      payLast  <= 1'b0;
      if (strb.clrPipe) fill <= '0;
      else if (strb.pushPay) begin
        if (fill == FULL) begin
          payValid <= 1'b1;
          payByte  <= dly[FCS_BYTES-1];
          payLast  <= strb.endPay;
        end else fill <= fill + 1'b1;
        dly[0] <= inByte;
        for (int i = 1; i < FCS_BYTES; i++) dly[i] <= dly[i-1];
      end
    end
  end
endmodule

// File: rtl/eth_rx_classifier.sv
module eth_rx_classifier
  import eth_rx_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int LT_W      = 16,
  parameter int FCS_BYTES = 4,
  parameter int MAX_LEN   = 1500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [7:0]        inByte,
  input  logic              inEnd,
  input  logic [ADDR_W-1:0] stationAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [LT_W-1:0]   lenType,
  output logic              hdrValid,
  output logic              addrMatch,
  output logic              isLength,
  output logic              payValid,
  output logic [7:0]        payByte,
  output logic              payLast,
  output logic              frameDone,
  output logic              runt
);
  localparam int HDR_BYTES = (2 * ADDR_W + LT_W) / 8;

  rxStrobe_t strb;

  eth_rx_ctrl #(.HDR_BYTES(HDR_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inByte(inByte), .inEnd(inEnd),
    .strb(strb), .hdrValid(hdrValid), .frameDone(frameDone), .runt(runt)
  );

  eth_rx_dp #(.ADDR_W(ADDR_W), .LT_W(LT_W), .FCS_BYTES(FCS_BYTES), .MAX_LEN(MAX_LEN)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .inByte(inByte), .staIn(stationAddr),
    .dstAddr(dstAddr), .srcAddr(srcAddr), .lenType(lenType), .addrMatch(addrMatch),
    .isLength(isLength), .payValid(payValid), .payByte(payByte), .payLast(payLast)
  );
endmodule

// File: rtl/eth_rx_checks.sv
module eth_rx_checks #(
  parameter int ADDR_W = 48,
  parameter int LT_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              inEnd,
  input logic              hdrValid,
  input logic              frameDone,
  input logic              runt,
  input logic              payValid,
  input logic              payLast,
  input logic [ADDR_W-1:0] dstAddr,
  input logic [ADDR_W-1:0] srcAddr,
  input logic [LT_W-1:0]   lenType
);
  // R3: header completion is a single-cycle pulse
  a_r3_hdr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hdrValid |=> !hdrValid);

  // R3/R6: captured fields do not move while payload is streaming
  a_r6_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    payValid |-> ($stable(dstAddr) && $stable(srcAddr) && $stable(lenType)));

  // R6: payload output only follows an accepted input byte
  a_r6_pay_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    payValid |-> $past(inValid));

  // R7: last marker only on a delivered byte, at frame end
  a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    payLast |-> (payValid && frameDone));

  // R8: runt only reported with completion, completion only after an end byte
  a_r8_runt_done: assert property (@(posedge clk) disable iff (!rst_n)
    runt |-> frameDone);

  a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |-> $past(inValid && inEnd));

  // R8: a frame whose header just completed is never a runt
  a_r8_hdr_not_runt: assert property (@(posedge clk) disable iff (!rst_n)
    hdrValid |-> !runt);
endmodule

bind eth_rx_classifier eth_rx_checks #(.ADDR_W(ADDR_W), .LT_W(LT_W)) u_chk (.*);

// File: tb/sim_eth_rx_classifier.sv
module sim_eth_rx_classifier;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] ALL1 = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inByte = '0;
  logic        inEnd = 1'b0;
  logic [47:0] stationAddr = '0;
  logic [47:0] dstAddr, srcAddr;
  logic [15:0] lenType;
  logic hdrValid, addrMatch, isLength, payValid, payLast, frameDone, runt;
  logic [7:0] payByte;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] gotPay [64];
  int payCnt, lastIdx, hdrCnt, doneCnt, runtCnt;

  eth_rx_classifier u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inByte(inByte), .inEnd(inEnd),
    .stationAddr(stationAddr), .dstAddr(dstAddr), .srcAddr(srcAddr), .lenType(lenType),
    .hdrValid(hdrValid), .addrMatch(addrMatch), .isLength(isLength), .payValid(payValid),
    .payByte(payByte), .payLast(payLast), .frameDone(frameDone), .runt(runt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    cycles++;
    if (payValid) begin
      if (payLast) lastIdx = payCnt;
      if (payCnt < 64) gotPay[payCnt] = payByte;
      payCnt++;
    end
    if (hdrValid) hdrCnt++;
    if (frameDone) doneCnt++;
    if (runt) runtCnt++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R8 watchdog expired: actual %0d cycles expected < 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clearMon();
    payCnt = 0; lastIdx = -1; hdrCnt = 0; doneCnt = 0; runtCnt = 0;
  endtask

  task automatic sendByte(input logic [7:0] b, input bit last);
    @(negedge clk);
    inValid = 1'b1; inByte = b; inEnd = last;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; inEnd = 1'b0; inByte = 8'h00;
    end
  endtask

  function automatic logic [7:0] hdrByte(input int i, input logic [47:0] d,
                                         input logic [47:0] s, input logic [15:0] lt);
    if (i < 6) return d[47-8*i -: 8];
    else if (i < 12) return s[47-8*(i-6) -: 8];
    else return lt[15-8*(i-12) -: 8];
  endfunction

  function automatic logic [7:0] restByte(input int j, input logic [15:0] lt);
    return 8'(j * 37 + int'(lt[7:0]) + 3);
  endfunction

  task automatic runFrame(input int nPre, input logic [47:0] d, input logic [47:0] s,
                          input logic [15:0] lt, input int nRest, input bit gap,
                          input logic [47:0] sta, input logic [47:0] staLater);
    int expN;
    int bad;
    clearMon();
    stationAddr = sta;
    for (int i = 0; i < nPre; i++) sendByte(8'h55, 1'b0);
    sendByte(8'hD5, 1'b0);
    stationAddr = staLater;
    for (int i = 0; i < 14; i++) begin
      sendByte(hdrByte(i, d, s, lt), (nRest == 0) && (i == 13));
      if (i == 13) chk(hdrValid === 1'b1, "R3", "hdrValid after 14th byte", 64'(hdrValid), 64'd1);
      if (gap && (i % 3 == 2)) idle(1);
    end
    for (int j = 0; j < nRest; j++) begin
      sendByte(restByte(j, lt), j == nRest - 1);
      if (gap && (j % 3 == 1) && (j != nRest - 1)) idle(1);
    end
    idle(3);
    expN = (nRest > 4) ? nRest - 4 : 0;
    chk(dstAddr === d, "R3", "dstAddr", 64'(dstAddr), 64'(d));
    chk(srcAddr === s, "R3", "srcAddr", 64'(srcAddr), 64'(s));
    chk(lenType === lt, "R3", "lenType", 64'(lenType), 64'(lt));
    chk(hdrCnt == 1, "R3", "hdrValid pulse count", 64'(hdrCnt), 64'd1);
    chk(isLength === (lt <= 16'd1500), "R4", "isLength", 64'(isLength), 64'(lt <= 16'd1500));
    chk(addrMatch === ((d == sta) || (d == ALL1)), "R5", "addrMatch",
        64'(addrMatch), 64'((d == sta) || (d == ALL1)));
    chk(payCnt == expN, "R6", "payload count", 64'(payCnt), 64'(expN));
    bad = 0;
    for (int j = 0; j < expN && j < 64; j++) if (gotPay[j] !== restByte(j, lt)) bad++;
    chk(bad == 0, "R6", "payload bytes wrong", 64'(bad), 64'd0);
    chk(lastIdx == expN - 1, "R7", "payLast index", 64'(lastIdx), 64'(expN - 1));
    chk(doneCnt == 1 && runtCnt == 0, "R8", "done/runt counts",
        64'(doneCnt * 16 + runtCnt), 64'd16);
  endtask

  task automatic runtFrame(input int nHdr);
    clearMon();
    sendByte(8'h55, 1'b0);
    sendByte(8'hD5, 1'b0);
    for (int i = 0; i < nHdr; i++) sendByte(8'h20 + 8'(i), i == nHdr - 1);
    idle(3);
    chk(doneCnt == 1, "R8", "frameDone count on short frame", 64'(doneCnt), 64'd1);
    chk(runtCnt == ((nHdr < 14) ? 1 : 0), "R8", "runt flag",
        64'(runtCnt), 64'((nHdr < 14) ? 1 : 0));
    chk(payCnt == 0, "R7", "no payload on short frame", 64'(payCnt), 64'd0);
  endtask

  task automatic noFrameCheck(input string req);
    chk(hdrCnt == 0, req, "header captured unexpectedly", 64'(hdrCnt), 64'd0);
    chk(doneCnt == 0, req, "frameDone unexpectedly", 64'(doneCnt), 64'd0);
  endtask

  initial begin
    logic [15:0] ltSet [8];
    logic [47:0] sta, d;
    ltSet = '{16'd0, 16'd46, 16'd1499, 16'd1500, 16'd1501, 16'd1536, 16'h0800, 16'hFFFF};

    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk(hdrValid === 1'b0, "R9", "hdrValid in reset", 64'(hdrValid), 64'd0);
    chk(frameDone === 1'b0 && runt === 1'b0, "R9", "frameDone/runt in reset",
        64'({frameDone, runt}), 64'd0);
    chk(payValid === 1'b0 && payLast === 1'b0, "R9", "payValid/payLast in reset",
        64'({payValid, payLast}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1 sweep over preamble length, length/type, tail length and address cases
    sta = 48'h0004A3_123456;
    for (int t = 0; t < 8; t++) begin
      for (int n = 0; n < 10; n++) begin
        int k;
        k = (t + n) % 4;
        case (k)
          0: d = sta;
          1: d = ALL1;
          2: d = sta ^ (48'd1 << ((t * 7 + n) % 48));
          default: d = sta;
        endcase
        runFrame(1 + (n % 7), d, 48'h0A1B2C_3D4E5F + 48'(t * 16 + n), ltSet[t], n, n[0],
                 sta, (k == 3) ? ~sta : sta);
      end
    end

    // R5: station changed after the delimiter to equal dst must not match
    runFrame(3, 48'hCAFE00_112233, 48'h1, 16'h0806, 12, 1'b0, 48'h0, 48'hCAFE00_112233);

    // R8: ends at every header position
    for (int n = 1; n <= 14; n++) runtFrame(n);

    // R2: abort on a foreign byte during the hunt
    clearMon();
    sendByte(8'h55, 1'b0); sendByte(8'h55, 1'b0); sendByte(8'h12, 1'b0);
    sendByte(8'hD5, 1'b0);
    for (int i = 0; i < 20; i++) sendByte(8'h30 + 8'(i), i == 19);
    idle(3);
    noFrameCheck("R2");

    // R2: end marker during the hunt
    clearMon();
    sendByte(8'h55, 1'b0); sendByte(8'h55, 1'b1);
    sendByte(8'hD5, 1'b0);
    for (int i = 0; i < 20; i++) sendByte(8'h30 + 8'(i), i == 19);
    idle(3);
    noFrameCheck("R2");

    // R1: a delimiter with no preceding pattern starts nothing
    clearMon();
    sendByte(8'hD5, 1'b0);
    for (int i = 0; i < 20; i++) sendByte(8'h30 + 8'(i), i == 19);
    idle(3);
    noFrameCheck("R1");

    // R1: recovery afterwards with a long preamble
    runFrame(7, ALL1, 48'h5, 16'd1500, 9, 1'b1, sta, sta);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule